// File: doc/BRIEF.md
# Memory Presence Descriptor Generator

This block turns an installed memory size, given in megabytes, into a 64-byte presence-detect descriptor. The descriptor is read out later, one byte at a time, by a serial interface outside this block. The table starts out as a fixed template. A start pulse launches a short sequential job with four steps:

- Split the size greedily into at most three power-of-two banks, one bank per clock.
- Derive the bank count, a density bitmap and a memory type code.
- Write those three values into fixed table positions.
- Recompute the closing checksum byte, one table byte per clock.

While the job runs, `busy` is high. When it ends, `done` rises and stays high until the next accepted start. If some of the memory cannot be described by the banks found, an error flag is raised. The read port is combinational and can be used at any time. During a run, any byte that has not yet been rewritten reads back its template value.

Top module: `pdg_gen`

## Requirements
- R1: After reset, busy, done and unrep are 0. The table holds the template: bytes 0..7 are 0x80, 0x08, 0xFF, 0x0D, 0x0A, 0xFF, 0x40, 0x00, bytes 8..62 are 0x00, and byte 63 is 0xDD, the 8-bit sum of bytes 0..62.
- R2: The decomposition works on a remaining size. It starts equal to size_mb, with a bank count of 0 and a density of 0. While the remaining size is at least 4 and fewer than 3 banks have been taken, one step runs:
  - L = floor(log2(remaining)), limited to 14;
  - the bank count increases by one;
  - density bit L-2 is set;
  - 2^L is subtracted from the remaining size.
- R3: If the bank count is exactly 1 and the density is above 1, the bank count becomes 2 and the density is shifted right by one.
- R4: If any density bit from 8 upward is set, the density byte becomes (density & 0xE0) | ((density >> 8) & 0x1F) and the type code is 0x08.
- R5: If no density bit from 8 upward is set, the type code is 0x08 when density bits 4..0 are all zero, and 0x04 otherwise.
- R6: At completion the table holds the template with three patches: byte 2 is the type code, byte 5 the bank count, and byte 31 the low eight bits of the density. Byte 63 is the 8-bit wrapping sum of bytes 0..62 taken after those patches.
- R7: unrep clears when a start is accepted. It is set at completion when the remaining size after decomposition is nonzero. It does not change while the block is idle.
- R8: A start is accepted only while busy is 0. An accepted start raises busy and clears done on the next edge. A start seen while busy is ignored. busy and done are never both high. done stays high until the next accepted start.
- R9: An accepted start puts the template back into the table. During a run, bytes 2, 5, 31 and 63 read their template values until they are rewritten.
- R10: done rises n + 65 clock edges after the edge that accepts start, where n is the number of banks taken before any split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted when idle |
| size_mb | input | SIZE_W | Installed memory size in megabytes |
| rd_addr | input | $clog2(TBL_DEPTH) | Table read address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished; held until next start |
| unrep | output | 1 | Part of the size could not be described |
| rd_data | output | 8 | Table byte at rd_addr |

## Verification
Two events can land in the same cycle: a new start pulse and a bank step or checksum step of a run already in progress. The bench provokes this by pulsing start with a second, different size three clocks into a run that uses all three banks and leaves a remainder. It judges the outcome by confirming that the finished table, the flag and the completion timing all match the first size only. A second overlap is a table read issued right after launch, while template restoration and patching share the cycle stream. Those reads must return template bytes.

// File: rtl/pdg_pkg.sv
`timescale 1ns/1ps
package pdg_pkg;

   localparam logic [7:0] TYPE_WIDE   = 8'h08;
   localparam logic [7:0] TYPE_NARROW = 8'h04;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SPLIT,
      ST_PATCH,
      ST_SUM
   } pdg_state_e;

   // fixed leading bytes of the descriptor, all others start at zero
   function automatic logic [7:0] seed_byte(input int unsigned i);
      case (i)
         0:       seed_byte = 8'h80;
         1:       seed_byte = 8'h08;
         2:       seed_byte = 8'hFF;
         3:       seed_byte = 8'h0D;
         4:       seed_byte = 8'h0A;
         5:       seed_byte = 8'hFF;
         6:       seed_byte = 8'h40;
         default: seed_byte = 8'h00;
      endcase
   endfunction

   // template byte, last entry carries the checksum of the others
   function automatic logic [7:0] tmpl_byte(input int unsigned i, input int unsigned depth);
      logic [7:0] s;
      s = 8'h00;
      if (i == depth - 1) begin
         for (int unsigned j = 0; j < depth - 1; j++) s = s + seed_byte(j);
         tmpl_byte = s;
      end else begin
         tmpl_byte = seed_byte(i);
      end
   endfunction

endpackage

// File: rtl/pdg_msb_enc.sv
`timescale 1ns/1ps
module pdg_msb_enc #(
   parameter int W  = 12,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] msb,
   output logic          any
);
   // highest set bit wins: later loop iterations override earlier ones
   always_comb begin
      msb = '0;
      for (int k = 0; k < W; k++) begin
         if (vec[k]) msb = IW'(k);
      end
   end

   assign any = |vec;
endmodule

// File: rtl/pdg_fold.sv
`timescale 1ns/1ps
module pdg_fold
   import pdg_pkg::*;
#(
   parameter int DEN_W = 16,
   parameter int BW    = 2
) (
   input  logic [BW-1:0]    banks_raw,
   input  logic [DEN_W-1:0] den_raw,
   output logic [BW-1:0]    banks_out,
   output logic [7:0]       den_byte,
   output logic [7:0]       type_code
);
   logic             split;
   logic [DEN_W-1:0] den_s;
   logic             hi_set;
   logic [DEN_W-1:0] den_up;

   always_comb begin
      split     = (banks_raw == BW'(1)) && (den_raw > DEN_W'(1));
      banks_out = split ? BW'(2) : banks_raw;
      den_s     = split ? (den_raw >> 1) : den_raw;
   end

   generate
      if (DEN_W > 8) begin : g_wide
         assign den_up = den_s >> 8;
         assign hi_set = |den_s[DEN_W-1:8];
      end else begin : g_narrow
         assign den_up = '0;
         assign hi_set = 1'b0;
      end
   endgenerate

   always_comb begin
      if (hi_set) begin
         den_byte  = (den_s[7:0] & 8'hE0) | {3'b000, den_up[4:0]};
         type_code = TYPE_WIDE;
      end else begin
         den_byte  = den_s[7:0];
         type_code = (den_s[4:0] == 5'd0) ? TYPE_WIDE : TYPE_NARROW;
      end
   end
endmodule

// File: rtl/pdg_gen.sv
`timescale 1ns/1ps
module pdg_gen
   import pdg_pkg::*;
#(
   parameter int SIZE_W    = 12,
   parameter int DEN_W     = 16,
   parameter int LOG_CAP   = 14,
   parameter int MAX_BANKS = 3,
   parameter int TBL_DEPTH = 64,
   parameter int TYPE_POS  = 2,
   parameter int BANK_POS  = 5,
   parameter int DEN_POS   = 31
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [SIZE_W-1:0]            size_mb,
   input  logic [$clog2(TBL_DEPTH)-1:0] rd_addr,
   output logic                         busy,
   output logic                         done,
   output logic                         unrep,
   output logic [7:0]                   rd_data
);
   localparam int AW      = $clog2(TBL_DEPTH);
   localparam int BW      = $clog2(MAX_BANKS + 1) < 2 ? 2 : $clog2(MAX_BANKS + 1);
   localparam int IW      = $clog2(SIZE_W);
   localparam int SUM_POS = TBL_DEPTH - 1;

   generate
      if (TBL_DEPTH != (1 << AW)) begin : g_bad_depth
         $error("TBL_DEPTH must be a power of two");
      end
      if (SIZE_W < 3) begin : g_bad_size
         $error("SIZE_W must be at least 3");
      end
      if (DEN_W < 13) begin : g_bad_den
         $error("DEN_W must be at least 13 for the fold");
      end
      if (LOG_CAP - 2 >= DEN_W || LOG_CAP < 2) begin : g_bad_cap
         $error("LOG_CAP out of range for DEN_W");
      end
      if (TYPE_POS >= SUM_POS || BANK_POS >= SUM_POS || DEN_POS >= SUM_POS) begin : g_bad_pos
         $error("patch positions must precede the checksum byte");
      end
   endgenerate

   pdg_state_e        state;
   logic [SIZE_W-1:0] rem;
   logic [BW-1:0]     banks;
   logic [DEN_W-1:0]  den;
   logic [AW-1:0]     idx;
   logic [7:0]        acc;
   logic [7:0]        tbl [TBL_DEPTH];

   // one bank step, computed from the current remainder
   logic [IW-1:0]     msb;
   logic              rem_any;
   logic [7:0]        lg;
   logic [SIZE_W-1:0] pow;
   logic [DEN_W-1:0]  den_bit;
   logic              step_ok;

   pdg_msb_enc #(.W(SIZE_W), .IW(IW)) u_enc (
      .vec (rem),
      .msb (msb),
      .any (rem_any)
   );

   always_comb begin
      lg      = (int'(msb) > LOG_CAP) ? 8'(LOG_CAP) : 8'(msb);
      pow     = SIZE_W'(1) << lg;
      den_bit = DEN_W'(1) << (lg - 8'd2);
      step_ok = rem_any && (rem >= SIZE_W'(4)) && (banks < BW'(MAX_BANKS));
   end

   logic [BW-1:0] banks_fix;
   logic [7:0]    den_byte;
   logic [7:0]    type_code;

   pdg_fold #(.DEN_W(DEN_W), .BW(BW)) u_fold (
      .banks_raw (banks),
      .den_raw   (den),
      .banks_out (banks_fix),
      .den_byte  (den_byte),
      .type_code (type_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         rem   <= '0;
         banks <= '0;
         den   <= '0;
         idx   <= '0;
         acc   <= '0;
         done  <= 1'b0;
         unrep <= 1'b0;
         for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= tmpl_byte(i, TBL_DEPTH);
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  rem   <= size_mb;
                  banks <= '0;
                  den   <= '0;
                  done  <= 1'b0;
                  unrep <= 1'b0;
                  for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= tmpl_byte(i, TBL_DEPTH);
                  state <= ST_SPLIT;
               end
            end
            ST_SPLIT: begin
               if (step_ok) begin
                  banks <= banks + BW'(1);
                  den   <= den | den_bit;
                  rem   <= rem - pow;
               end else begin
                  state <= ST_PATCH;
               end
            end
            ST_PATCH: begin
               tbl[TYPE_POS] <= type_code;
               tbl[BANK_POS] <= 8'(banks_fix);
               tbl[DEN_POS]  <= den_byte;
               unrep         <= (rem != '0);
               idx           <= '0;
               acc           <= '0;
               state         <= ST_SUM;
            end
            ST_SUM: begin
               acc <= acc + tbl[idx];
               idx <= idx + AW'(1);
               if (idx == AW'(SUM_POS - 1)) begin
                  tbl[SUM_POS] <= acc + tbl[idx];
                  done         <= 1'b1;
                  state        <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign rd_data = tbl[rd_addr];
endmodule

// File: rtl/pdg_gen_chk.sv
`timescale 1ns/1ps
module pdg_gen_chk #(
   parameter int LIMIT = 68
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic unrep
);
   localparam int CW = $clog2(LIMIT + 2);
   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= (run_cnt == CW'(LIMIT + 1)) ? run_cnt : run_cnt + CW'(1);
      else           run_cnt <= '0;
   end

   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) done && !start |=> done);
   // R8
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy && !done);
   // R8
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy && !done |=> !done);
   // R7
   unrep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> !unrep);
   // R7
   unrep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy && !start |=> $stable(unrep));
   // R10
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> run_cnt < CW'(LIMIT));
endmodule

bind pdg_gen pdg_gen_chk #(.LIMIT(MAX_BANKS + TBL_DEPTH + 1)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .unrep (unrep)
);

// File: tb/pdg_gen_test.sv
`timescale 1ns/1ps
module pdg_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [11:0] size_mb = '0;
   logic [5:0] rd_addr = '0;
   logic       busy, done, unrep;
   logic [7:0] rd_data;

   int n_checks = 0;
   int n_errors = 0;
   int exp_tbl [64];

   always #10 clk = ~clk;

   pdg_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .size_mb(size_mb),
      .rd_addr(rd_addr), .busy(busy), .done(done), .unrep(unrep), .rd_data(rd_data)
   );

   initial begin
      #3_000_000;
      n_errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int base_byte(input int i);
      int v;
      case (i)
         0: v = 'h80; 1: v = 'h08; 2: v = 'hFF; 3: v = 'h0D;
         4: v = 'h0A; 5: v = 'hFF; 6: v = 'h40; default: v = 0;
      endcase
      if (i == 63) begin
         v = 0;
         for (int j = 0; j < 63; j++) v = (v + base_byte(j)) & 255;
      end
      return v;
   endfunction

   // expected fields from the decomposition rules
   task automatic model(input int sz, output int typ, output int nb, output int db,
                        output int unr, output int raw);
      int rem, b, d, lg;
      rem = sz; b = 0; d = 0;
      while (rem >= 4 && b <= 2) begin
         lg = 0;
         for (int k = 0; k < 31; k++) if ((rem >> k) & 1) lg = k;
         if (lg > 14) lg = 14;
         b++;
         d = d | (1 << (lg - 2));
         rem = rem - (1 << lg);
      end
      raw = b;
      if (b == 1 && d > 1) begin b = 2; d = d >> 1; end
      if ((d & 'hFF00) != 0) begin
         d = (d & 'hE0) | ((d >> 8) & 'h1F);
         typ = 8;
      end else if ((d & 'h1F) == 0) typ = 8;
      else typ = 4;
      nb = b; db = d & 255; unr = (rem != 0);
   endtask

   task automatic build_exp(input int typ, input int nb, input int db);
      int s;
      for (int i = 0; i < 64; i++) exp_tbl[i] = base_byte(i);
      exp_tbl[2] = typ; exp_tbl[5] = nb; exp_tbl[31] = db;
      s = 0;
      for (int i = 0; i < 63; i++) s = (s + exp_tbl[i]) & 255;
      exp_tbl[63] = s;
   endtask

   task automatic read_at(input int a, output int v);
      rd_addr = 6'(a);
      #1;
      v = int'(rd_data);
   endtask

   // one full run; an optional second start lands mid-run
   task automatic run_one(input int sz, input bit inject, input int other);
      int typ, nb, db, unr, raw, v, edges;
      model(sz, typ, nb, db, unr, raw);
      build_exp(typ, nb, db);
      size_mb = 12'(sz);
      start = 1'b1;
      tick();
      start = 1'b0;
      edges = 0;
      check(busy === 1'b1 && done === 1'b0, "R8 busy after start", int'({busy, done}), 2);
      check(unrep === 1'b0, "R7 unrep cleared on start", int'(unrep), 0);
      read_at(2, v);
      check(v == 'hFF, "R9 byte 2 template during run", v, 'hFF);
      read_at(63, v);
      check(v == 'hDD, "R9 byte 63 template during run", v, 'hDD);
      while (!done && edges < 200) begin
         if (inject && edges == 2) begin
            size_mb = 12'(other);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         tick();
         edges++;
         if (busy && done) check(1'b0, "R8 busy and done together", 3, 0);
      end
      start = 1'b0;
      check(edges == raw + 65, "R10 completion timing", edges, raw + 65);
      check(unrep === 1'(unr), "R7 unrep flag", int'(unrep), unr);
      read_at(2, v);  check(v == typ, "R4 R5 type code byte", v, typ);
      read_at(5, v);  check(v == nb, "R2 R3 bank count byte", v, nb);
      read_at(31, v); check(v == db, "R2 R4 density byte", v, db);
      read_at(63, v); check(v == exp_tbl[63], "R6 checksum byte", v, exp_tbl[63]);
      for (int i = 0; i < 63; i++) begin
         read_at(i, v);
         if (v != exp_tbl[i]) check(1'b0, "R6 table byte", v, exp_tbl[i]);
      end
      n_checks++;
   endtask

   initial begin
      int v;
      void'($urandom(32'h5EED1234));
      #25;
      rst_n = 1'b1;
      tick();
      // R1 reset contents
      check(busy === 1'b0 && done === 1'b0 && unrep === 1'b0, "R1 reset flags",
            int'({busy, done, unrep}), 0);
      for (int i = 0; i < 64; i++) begin
         read_at(i, v);
         check(v == base_byte(i), "R1 reset table byte", v, base_byte(i));
      end
      // directed corners
      run_one(0, 1'b0, 0);
      run_one(3, 1'b0, 0);
      run_one(4, 1'b0, 0);
      run_one(5, 1'b0, 0);
      run_one(8, 1'b0, 0);       // R3 split single bank
      run_one(12, 1'b0, 0);
      run_one(7, 1'b0, 0);       // R7 remainder 3
      run_one(256, 1'b0, 0);
      run_one(1024, 1'b0, 0);
      run_one(2048, 1'b0, 0);    // R4 fold after split
      run_one(3072, 1'b0, 0);    // R4 fold two banks
      run_one(4095, 1'b0, 0);    // R2 three bank cap
      // R8 start while busy is ignored
      run_one(4095, 1'b1, 8);
      // R8 done held while idle
      repeat (5) tick();
      check(done === 1'b1 && busy === 1'b0, "R8 done held", int'({busy, done}), 1);
      check(unrep === 1'b1, "R7 unrep stable while idle", int'(unrep), 1);
      for (int n = 0; n < 40; n++) run_one(int'($urandom % 4096), 1'b0, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule